// File: doc/BRIEF.md
# Strobed Serial Register Slave

This block is a small register file on the device side of a three-wire serial link (serial clock, serial data in, serial data out) that has no chip select. A separate active-low strobe line marks the one clock pulse that commits a transfer. The shift logic is always enabled. Address and data travel through one shared shift register. A write sends the 32-bit data word first and the 8-bit address last, then commits with the data-in line held high. A read sends only the 8-bit address, commits with the data-in line held low, and then clocks the selected register out on the data-out line, most significant bit first.

The block keeps three read-write registers: a mode word, a multiplexer word and a reset word. Bit 0 of the reset word drives a reset-request output toward the host processor. It also decodes a read-only switch register, which returns the synchronized switch inputs, and a read-only version register, which returns a fixed parameter. The serial pins are synchronized into the system clock domain and edge-detected there. The serial clock must therefore run well below the system clock: each pin level has to be held for at least four system cycles.

Top module: `sreg_strobe_slave`

## Requirements
- R1: A synchronous active-low system reset clears the mode word, the multiplexer word and the reset word to zero, drives `reset_req_o` low and drives the serial output low.
- R2: On each rising serial-clock edge seen while the strobe is high, the 40-bit shift register moves one place toward its MSB and takes the data-in level into bit 0. After a 40-bit write frame, bits 39..8 hold the data word and bits 7..0 hold the address.
- R3: A rising serial-clock edge seen while the strobe is low is a commit edge and does not shift. A data-in level of 1 on that edge selects a write and a level of 0 selects a read.
- R4: A write commit to address 0x00 stores the word in the mode register and drives it on `mode_o`. A write commit to address 0x02 does the same for the multiplexer register and `mux_o`.
- R5: A write commit to address 0x80 stores the full word in the reset register. `reset_req_o` equals bit 0 of that word, and a read of 0x80 returns the full word.
- R6: A read commit loads the selected register into the upper 32 bits of the shift register. The serial output shows bit 31 after the commit's falling clock edge and the next lower bit after each following falling edge, so a host that samples before each of 32 rising edges receives the word MSB first.
- R7: A read of address 0x08 returns the synchronized switch inputs, zero-extended to 32 bits. A read of 0xFF returns the `VERSION` parameter.
- R8: A write commit to 0x08, to 0xFF or to any unmapped address leaves `mode_o`, `mux_o`, `reset_req_o` and every stored register unchanged.
- R9: A read of any address other than 0x00, 0x02, 0x08, 0x80 and 0xFF returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from the host, low at idle |
| ser_din_i | input | 1 | Serial data from the host; gives the direction on a commit edge |
| ser_stb_n_i | input | 1 | Active-low commit strobe, high at idle |
| ser_dout_o | output | 1 | Serial read data toward the host |
| sw_i | input | SW_W | Asynchronous switch inputs |
| mode_o | output | 32 | Mode register contents |
| mux_o | output | 32 | Multiplexer register contents |
| reset_req_o | output | 1 | Reset request to the host processor (bit 0 of the reset register) |

## Verification
Direction sampling and shifting both depend on the same rising serial-clock edge, and only the level of the strobe at that edge decides which one happens. The bench provokes this coincidence with frames whose stale shift contents look like a valid write: it shifts a full data word and the mode address, then commits with the data-in line low. The mode output must stay unchanged and the read-back must return the old mode value. A write commit whose shift register is not left untouched, or a read-back shifted off by one place, shows up as a miscompare against the bench model. Constrained random reads and writes over the mapped and unmapped addresses, with the switch inputs changed between transfers, are compared word for word against that model.

// File: rtl/ssr_pkg.sv
// Package: shared widths and register addresses of the strobed serial slave.
// Assumes one 8-bit address space with fully decoded addresses.
package ssr_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int SR_W   = DATA_W + ADDR_W;

    localparam logic [ADDR_W-1:0] A_MODE    = 8'h00;
    localparam logic [ADDR_W-1:0] A_MUX     = 8'h02;
    localparam logic [ADDR_W-1:0] A_SWITCH  = 8'h08;
    localparam logic [ADDR_W-1:0] A_RESET   = 8'h80;
    localparam logic [ADDR_W-1:0] A_VERSION = 8'hFF;

    typedef enum logic [1:0] {
        CMT_NONE  = 2'd0,
        CMT_READ  = 2'd1,
        CMT_WRITE = 2'd2
    } commit_e;
endpackage

// File: rtl/ssr_sync.sv
// Module: multi-stage synchronizer for a bus of independent asynchronous bits.
// Assumes each bit is a quasi-static level; no coherency across bits is given.
module ssr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    input  logic [W-1:0] rst_val_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    // Chain of flops; stage 0 samples the asynchronous input.
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= rst_val_i;
                    else        stage_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= rst_val_i;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ssr_shift.sv
// Module: serial front end. Edge-detects the synchronized serial clock, shifts
// address/data MSB first, decodes commit edges and drives the serial output.
// Assumes synchronized inputs that hold each level for several system cycles.
module ssr_shift
    import ssr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s_i,
    input  logic              din_s_i,
    input  logic              stb_n_s_i,
    input  logic [DATA_W-1:0] load_data_i,
    output commit_e           commit_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              dout_o
);
    logic            sclk_q;
    logic            rise;
    logic            fall;
    logic [SR_W-1:0] sr_q;
    logic            dout_q;

    // Previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s_i;
    end

    assign rise = sclk_s_i & ~sclk_q;
    assign fall = ~sclk_s_i & sclk_q;

    // Classify a rising edge: shift when the strobe is high, commit when it is low.
    always_comb begin
        commit_o = CMT_NONE;
        if (rise && !stb_n_s_i) commit_o = din_s_i ? CMT_WRITE : CMT_READ;
    end

    // Shared address/data shift register; a read commit loads the data part.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (rise && stb_n_s_i) begin
            sr_q <= {sr_q[SR_W-2:0], din_s_i};
        end else if (commit_o == CMT_READ) begin
            sr_q <= {load_data_i, sr_q[ADDR_W-1:0]};
        end
    end

    // Serial output changes only on falling serial clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n)    dout_q <= 1'b0;
        else if (fall) dout_q <= sr_q[SR_W-1];
    end

    assign addr_o  = sr_q[ADDR_W-1:0];
    assign wdata_o = sr_q[SR_W-1:ADDR_W];
    assign dout_o  = dout_q;

    // R2: a shift edge moves every bit one place toward the MSB
    a_r2_shift_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && stb_n_s_i) |=> sr_q[SR_W-1:1] == $past(sr_q[SR_W-2:0]));
    // R3: a write commit edge leaves the shift register untouched
    a_r3_write_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !stb_n_s_i && din_s_i) |=> $stable(sr_q));
    // R3: without a rising edge nothing moves
    a_r3_hold_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(sr_q));
    // R6: a read commit keeps the address bits and loads the word above them
    a_r6_read_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !stb_n_s_i && !din_s_i) |=>
            (sr_q[ADDR_W-1:0] == $past(sr_q[ADDR_W-1:0])) &&
            (sr_q[SR_W-1:ADDR_W] == $past(load_data_i)));
    // R6: the serial output only changes after a falling edge
    a_r6_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(dout_q));
endmodule

// File: rtl/ssr_regfile.sv
// Module: register storage, address decode and read multiplexer.
// Assumes a single-cycle write strobe and a combinational read address.
module ssr_regfile
    import ssr_pkg::*;
#(
    parameter int                SW_W    = 8,
    parameter logic [DATA_W-1:0] VERSION = 32'h5A17_0C03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SW_W-1:0]   sw_s_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] mode_o,
    output logic [DATA_W-1:0] mux_o,
    output logic [DATA_W-1:0] rst_word_o
);
    localparam int PAD_W = DATA_W - SW_W;

    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] mux_q;
    logic [DATA_W-1:0] rst_q;
    logic              hit_mode;
    logic              hit_mux;
    logic              hit_rst;

    assign hit_mode = (addr_i == A_MODE);
    assign hit_mux  = (addr_i == A_MUX);
    assign hit_rst  = (addr_i == A_RESET);

    // Writable registers; read-only and unmapped addresses fall through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            mux_q  <= '0;
            rst_q  <= '0;
        end else if (we_i) begin
            if (hit_mode) mode_q <= wdata_i;
            if (hit_mux)  mux_q  <= wdata_i;
            if (hit_rst)  rst_q  <= wdata_i;
        end
    end

    // Read multiplexer; unmapped addresses read as zero.
    always_comb begin
        unique case (addr_i)
            A_MODE:    rdata_o = mode_q;
            A_MUX:     rdata_o = mux_q;
            A_SWITCH:  rdata_o = {{PAD_W{1'b0}}, sw_s_i};
            A_RESET:   rdata_o = rst_q;
            A_VERSION: rdata_o = VERSION;
            default:   rdata_o = '0;
        endcase
    end

    assign mode_o     = mode_q;
    assign mux_o      = mux_q;
    assign rst_word_o = rst_q;

    // R1: reset clears all stored words
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (mode_q == '0) && (mux_q == '0) && (rst_q == '0));
    // R4: a mode write lands in the mode register
    a_r4_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_MODE) |=> mode_q == $past(wdata_i));
    // R5: a reset-register write lands in the reset register
    a_r5_reset_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_RESET) |=> rst_q == $past(wdata_i));
    // R8: writes to read-only or unmapped addresses change nothing
    a_r8_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i != A_MODE && addr_i != A_MUX && addr_i != A_RESET) |=>
            $stable(mode_q) && $stable(mux_q) && $stable(rst_q));
    // R9: unmapped reads return zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i != A_MODE && addr_i != A_MUX && addr_i != A_SWITCH &&
         addr_i != A_RESET && addr_i != A_VERSION) |-> rdata_o == '0);
endmodule

// File: rtl/sreg_strobe_slave.sv
// Module: top of the strobed serial register slave. Synchronizes the serial
// pins and switch inputs, then joins the serial front end to the register file.
// Assumes the host holds each serial pin level for at least four system cycles.
module sreg_strobe_slave
    import ssr_pkg::*;
#(
    parameter int                SW_W    = 8,
    parameter logic [DATA_W-1:0] VERSION = 32'h5A17_0C03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_din_i,
    input  logic              ser_stb_n_i,
    output logic              ser_dout_o,
    input  logic [SW_W-1:0]   sw_i,
    output logic [DATA_W-1:0] mode_o,
    output logic [DATA_W-1:0] mux_o,
    output logic              reset_req_o
);
    logic [2:0]        pins_s;
    logic [SW_W-1:0]   sw_s;
    commit_e           commit;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] rst_word;

    // Serial pins share one synchronizer so their relative timing is kept.
    ssr_sync #(.W(3), .STAGES(2)) u_pin_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .d_i       ({ser_clk_i, ser_din_i, ser_stb_n_i}),
        .rst_val_i (3'b001),
        .q_o       (pins_s)
    );

    ssr_sync #(.W(SW_W), .STAGES(2)) u_sw_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .d_i       (sw_i),
        .rst_val_i ('0),
        .q_o       (sw_s)
    );

    ssr_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s_i    (pins_s[2]),
        .din_s_i     (pins_s[1]),
        .stb_n_s_i   (pins_s[0]),
        .load_data_i (rdata),
        .commit_o    (commit),
        .addr_o      (addr),
        .wdata_o     (wdata),
        .dout_o      (ser_dout_o)
    );

    ssr_regfile #(.SW_W(SW_W), .VERSION(VERSION)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (commit == CMT_WRITE),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .sw_s_i     (sw_s),
        .rdata_o    (rdata),
        .mode_o     (mode_o),
        .mux_o      (mux_o),
        .rst_word_o (rst_word)
    );

    assign reset_req_o = rst_word[0];

    // R5: the reset request follows bit 0 of the reset register
    a_r5_req_follows_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o == rst_word[0]);
    // R1: reset drops the request and the serial output
    a_r1_outputs_low: assert property (@(posedge clk)
        !rst_n |=> !reset_req_o && !ser_dout_o);
endmodule

// File: tb/sreg_strobe_slave_tb.sv
module sreg_strobe_slave_tb;
    localparam int          PH      = 6;
    localparam int          SW_W    = 8;
    localparam logic [31:0] VERSION = 32'h5A17_0C03;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_din = 1'b0;
    logic        ser_stb_n = 1'b1;
    logic        ser_dout;
    logic [7:0]  sw = '0;
    logic [31:0] mode_o, mux_o;
    logic        reset_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_mode = '0, m_mux = '0, m_rst = '0;

    always #10 clk = ~clk;

    sreg_strobe_slave #(.SW_W(SW_W), .VERSION(VERSION)) u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_din_i(ser_din),
        .ser_stb_n_i(ser_stb_n), .ser_dout_o(ser_dout), .sw_i(sw),
        .mode_o(mode_o), .mux_o(mux_o), .reset_req_o(reset_req)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_mode;
            8'h02:   return m_mux;
            8'h08:   return {24'h0, sw};
            8'h80:   return m_rst;
            8'hFF:   return VERSION;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wait_sys(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_bit(input logic b);
        ser_din = b;
        wait_sys(PH); ser_clk = 1'b1;
        wait_sys(PH); ser_clk = 1'b0;
        wait_sys(PH);
    endtask

    task automatic strobe(input logic dir);
        ser_din = dir;
        wait_sys(PH); ser_stb_n = 1'b0;
        wait_sys(PH); ser_clk = 1'b1;
        wait_sys(PH); ser_clk = 1'b0;
        wait_sys(PH); ser_stb_n = 1'b1;
        wait_sys(PH);
    endtask

    task automatic shift_frame(input logic [7:0] a, input logic [31:0] d);
        for (int i = 31; i >= 0; i--) pin_bit(d[i]);
        for (int i = 7; i >= 0; i--) pin_bit(a[i]);
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        shift_frame(a, d);
        strobe(1'b1);
        case (a)
            8'h00: m_mode = d;
            8'h02: m_mux = d;
            8'h80: m_rst = d;
            default: ;
        endcase
    endtask

    task automatic readout(output logic [31:0] r);
        for (int i = 31; i >= 0; i--) begin
            ser_din = 1'($urandom);
            wait_sys(PH);
            r[i] = ser_dout;
            ser_clk = 1'b1; wait_sys(PH);
            ser_clk = 1'b0; wait_sys(PH);
        end
    endtask

    task automatic host_read(input logic [7:0] a, output logic [31:0] r);
        for (int i = 7; i >= 0; i--) pin_bit(a[i]);
        strobe(1'b0);
        readout(r);
    endtask

    task automatic check_outputs(input string req);
        check({req, " mode_o"}, mode_o, m_mode);
        check({req, " mux_o"}, mux_o, m_mux);
        check({req, " reset_req_o"}, {31'h0, reset_req}, {31'h0, m_rst[0]});
    endtask

    initial begin
        wait_sys(190000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  a;
        logic [31:0] d;
        void'($urandom(32'h1EAF));
        wait_sys(5);
        // R1: reset state
        check("R1 mode_o", mode_o, 32'h0);
        check("R1 mux_o", mux_o, 32'h0);
        check("R1 reset_req_o", {31'h0, reset_req}, 32'h0);
        check("R1 ser_dout_o", {31'h0, ser_dout}, 32'h0);
        rst_n = 1'b1;
        wait_sys(4);

        // R2 R4 R6: mode write and MSB-first read-back
        host_write(8'h00, 32'h8001_C3A5);
        check_outputs("R4");
        host_read(8'h00, r);
        check("R6 R2 mode readback", r, 32'h8001_C3A5);
        host_write(8'h02, 32'h1234_5678);
        check_outputs("R4");
        host_read(8'h02, r);
        check("R6 mux readback", r, 32'h1234_5678);

        // R3: full write-like frame committed as a read must not write
        shift_frame(8'h00, 32'hDEAD_BEEF);
        strobe(1'b0);
        readout(r);
        check("R3 read commit returns old mode", r, m_mode);
        check_outputs("R3");

        // R5: reset register
        host_write(8'h80, 32'h0000_0001);
        check_outputs("R5");
        check("R5 req high", {31'h0, reset_req}, 32'h1);
        host_write(8'h80, 32'hFFFF_FFFE);
        check("R5 req low", {31'h0, reset_req}, 32'h0);
        host_read(8'h80, r);
        check("R5 readback", r, 32'hFFFF_FFFE);

        // R7: version and switches
        host_read(8'hFF, r);
        check("R7 version", r, VERSION);
        sw = 8'hA6; wait_sys(8);
        host_read(8'h08, r);
        check("R7 switches", r, 32'h0000_00A6);

        // R8: ignored writes
        host_write(8'h08, 32'hFFFF_FFFF);
        check_outputs("R8");
        host_write(8'hFF, 32'h0BAD_0BAD);
        check_outputs("R8");
        host_read(8'hFF, r);
        check("R8 version kept", r, VERSION);
        host_write(8'h81, 32'h0000_0001);
        check_outputs("R8");

        // R9: unmapped reads
        host_read(8'h01, r);
        check("R9 unmapped 01", r, 32'h0);
        host_read(8'h7F, r);
        check("R9 unmapped 7F", r, 32'h0);

        // Random mix over mapped and unmapped addresses
        for (int k = 0; k < 60; k++) begin
            logic [7:0] amap [6];
            amap = '{8'h00, 8'h02, 8'h08, 8'h80, 8'hFF, 8'h00};
            amap[5] = 8'($urandom);
            a = amap[$urandom_range(0, 5)];
            d = $urandom;
            sw = 8'($urandom);
            wait_sys(8);
            if ($urandom_range(0, 1) == 1) begin
                host_write(a, d);
                check_outputs("R4 R5 R8 random write");
            end else begin
                host_read(a, r);
                check("R6 R7 R9 random read", r, exp_read(a));
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule